// File: doc/BRIEF.md
# Per-Peer Beamforming Weight Selector

This block sits on the MAC side of a radio with analogue beamforming. It keeps a small table of peer stations. Each row holds a 48-bit station address, a valid bit and one complex weight per antenna. Software fills the table and a default weight vector through a plain write port. Three frame events from the MAC pick which vector goes to the PHY:

- a transmit request carries the destination address, which is looked up in the table;
- a received RTS carries the sender's address, which is looked up so that the following data frame is received with that peer's weights;
- the end of a frame exchange applies the default vector, which must be good enough to hear a short RTS from any station.

Each decision reaches the PHY as one transfer. A transfer is a single-cycle valid pulse carrying the whole vector, and the PHY acknowledges it. Only one event waits at a time; a newer event replaces an older one that has not yet been served. A lookup that finds no valid row sends the default vector and raises a miss flag with the pulse. The delivered vector is a registered snapshot, so table writes never disturb a transfer already made.

Top module: `link_weight_ctrl`

## Requirements
- R1: After reset, `phy_valid` and `lkp_miss` are 0, `phy_vec` is all zeros, every table row is invalid, and the default vector is all zeros.
- R2: A write with `cfg_we` high stores `cfg_mac`, `cfg_vld` and `cfg_vec` into row `cfg_idx`. Any lookup served from the next cycle on uses the new contents.
- R3: If `tx_req` is high in cycle c while the block is idle with nothing pending, `phy_valid` is high in cycle c+2. If a valid row matches `tx_dst`, `phy_vec` carries that row's vector and `lkp_miss` is 0.
- R4: `rts_seen` with `rts_src` behaves as R3, looking up the RTS sender's address.
- R5: `xchg_done` leads to a transfer of the stored default vector with the same c+2 timing, and `lkp_miss` is 0. A `dflt_we` write is used by every default transfer served from the following cycle on.
- R6: A lookup with no valid matching row (rows with valid 0 never match) transfers the default vector with `lkp_miss` high in the same cycle as `phy_valid`. `lkp_miss` is never high without `phy_valid`.
- R7: When several valid rows hold the searched address, the row with the lowest index supplies the vector.
- R8: `phy_valid` lasts exactly one cycle. After a pulse, no further pulse appears until `phy_ack` has been sampled high in the pulse cycle or in a later cycle.
- R9: Events arriving while a transfer awaits acknowledgement are held in one slot, and only the newest is kept. If `phy_ack` is high in cycle a, the held event is delivered with `phy_valid` high in cycle a+2.
- R10: Events raised in the same cycle are ranked transmit request first, then RTS, then exchange end; only the highest-ranked one is kept.
- R11: `phy_vec` changes only in a cycle where `phy_valid` is high. Writes to the table or to the default vector affect only later transfers.
- R12: Vector layout: antenna k uses bits [16k+7:16k] for the in-phase part and [16k+15:16k+8] for the quadrature part.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table row write strobe |
| cfg_idx | input | 4 | Row index to write |
| cfg_vld | input | 1 | Valid bit for the written row |
| cfg_mac | input | 48 | Station address for the written row |
| cfg_vec | input | 64 | Weight vector for the written row |
| dflt_we | input | 1 | Default vector write strobe |
| dflt_vec | input | 64 | New default weight vector |
| tx_req | input | 1 | Transmit about to start (one-cycle event) |
| tx_dst | input | 48 | Destination address of the transmit |
| rts_seen | input | 1 | RTS frame received (one-cycle event) |
| rts_src | input | 48 | Sender address of the RTS |
| xchg_done | input | 1 | Frame exchange sequence finished (one-cycle event) |
| phy_valid | output | 1 | One-cycle weight transfer pulse |
| phy_ack | input | 1 | PHY acknowledgement of the last transfer |
| phy_vec | output | 64 | Delivered weight vector, held between transfers |
| lkp_miss | output | 1 | Lookup found no valid row; high with the pulse |

## Verification
The assertions assume the following about the inputs:
- `phy_ack` is raised only while a transfer is outstanding;
- event strobes and write strobes are known (never X) after reset;
- the address presented with an event is stable in the cycle the strobe is high.

The stimulus keeps within these limits. All inputs are driven on the falling edge. `phy_ack` is asserted only in or after the pulse cycle, and only for one cycle. Addresses and vectors come from a closed-form function of the row index, so every row is distinct except where a duplicate is planted on purpose.

// File: rtl/lwt_pkg.sv
package lwt_pkg;

    // Kind of frame event waiting to be served
    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_TX   = 2'd1,
        EV_RTS  = 2'd2,
        EV_DONE = 2'd3
    } ev_kind_t;

    // Transfer controller state
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } ctl_st_t;

endpackage

// File: rtl/lwt_table.sv
module lwt_table #(
    parameter int ENTRIES = 16,
    parameter int AW      = 48,
    parameter int VW      = 64,
    localparam int IW     = $clog2(ENTRIES)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [IW-1:0]                  wr_idx,
    input  logic                           wr_vld,
    input  logic [AW-1:0]                  wr_mac,
    input  logic [VW-1:0]                  wr_vec,
    output logic [ENTRIES-1:0]             tab_vld,
    output logic [ENTRIES-1:0][AW-1:0]     tab_mac,
    output logic [ENTRIES-1:0][VW-1:0]     tab_vec
);

    typedef struct packed {
        logic [ENTRIES-1:0]         vld;
        logic [ENTRIES-1:0][AW-1:0] mac;
        logic [ENTRIES-1:0][VW-1:0] vec;
    } tab_t;

    tab_t ts_d, ts_q;

    always_comb begin
        ts_d = ts_q;
        if (wr_en) begin
            ts_d.vld[wr_idx] = wr_vld;
            ts_d.mac[wr_idx] = wr_mac;
            ts_d.vec[wr_idx] = wr_vec;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ts_q <= '0;
        else        ts_q <= ts_d;
    end

    assign tab_vld = ts_q.vld;
    assign tab_mac = ts_q.mac;
    assign tab_vec = ts_q.vec;

    // R2: a write lands in the addressed row on the next cycle
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (tab_vld[$past(wr_idx)] == $past(wr_vld))
               && (tab_mac[$past(wr_idx)] == $past(wr_mac))
               && (tab_vec[$past(wr_idx)] == $past(wr_vec)));

endmodule

// File: rtl/lwt_match.sv
module lwt_match #(
    parameter int ENTRIES = 16,
    parameter int AW      = 48,
    localparam int IW     = $clog2(ENTRIES)
) (
    input  logic [AW-1:0]               key,
    input  logic [ENTRIES-1:0]          tab_vld,
    input  logic [ENTRIES-1:0][AW-1:0]  tab_mac,
    output logic                        hit,
    output logic [IW-1:0]               hit_idx
);

    logic [ENTRIES-1:0] eq;

    // One comparator per row; an invalid row never matches
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign eq[g] = tab_vld[g] && (tab_mac[g] == key);
    end

    // Lowest matching index wins: scan from the top so low rows override
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (eq[i]) begin
                hit     = 1'b1;
                hit_idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/link_weight_ctrl.sv
module link_weight_ctrl #(
    parameter int ENTRIES = 16,
    parameter int MAC_W   = 48,
    parameter int NANT    = 4,
    parameter int WBITS   = 8,
    localparam int IW     = $clog2(ENTRIES),
    localparam int VW     = NANT * 2 * WBITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IW-1:0]     cfg_idx,
    input  logic              cfg_vld,
    input  logic [MAC_W-1:0]  cfg_mac,
    input  logic [VW-1:0]     cfg_vec,
    input  logic              dflt_we,
    input  logic [VW-1:0]     dflt_vec,
    input  logic              tx_req,
    input  logic [MAC_W-1:0]  tx_dst,
    input  logic              rts_seen,
    input  logic [MAC_W-1:0]  rts_src,
    input  logic              xchg_done,
    output logic              phy_valid,
    input  logic              phy_ack,
    output logic [VW-1:0]     phy_vec,
    output logic              lkp_miss
);
    import lwt_pkg::*;

    typedef struct packed {
        ctl_st_t           st;
        ev_kind_t          pend;
        logic [MAC_W-1:0]  pend_key;
        logic [VW-1:0]     dflt;
        logic [VW-1:0]     vec;
        logic              wv;
        logic              miss;
    } ctl_t;

    ctl_t cs_q, cs_d;

    logic [ENTRIES-1:0]             tab_vld;
    logic [ENTRIES-1:0][MAC_W-1:0]  tab_mac;
    logic [ENTRIES-1:0][VW-1:0]     tab_vec;
    logic                           m_hit;
    logic [IW-1:0]                  m_idx;
    logic                           serve;

    lwt_table #(.ENTRIES(ENTRIES), .AW(MAC_W), .VW(VW)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_idx  (cfg_idx),
        .wr_vld  (cfg_vld),
        .wr_mac  (cfg_mac),
        .wr_vec  (cfg_vec),
        .tab_vld (tab_vld),
        .tab_mac (tab_mac),
        .tab_vec (tab_vec)
    );

    lwt_match #(.ENTRIES(ENTRIES), .AW(MAC_W)) u_match (
        .key     (cs_q.pend_key),
        .tab_vld (tab_vld),
        .tab_mac (tab_mac),
        .hit     (m_hit),
        .hit_idx (m_idx)
    );

    assign serve = (cs_q.st == ST_IDLE) && (cs_q.pend != EV_NONE);

    always_comb begin
        cs_d      = cs_q;
        cs_d.wv   = 1'b0;
        cs_d.miss = 1'b0;

        if (dflt_we) cs_d.dflt = dflt_vec;

        // Deliver the pending decision as one snapshot
        if (serve) begin
            cs_d.wv = 1'b1;
            cs_d.st = ST_WAIT;
            if (cs_q.pend == EV_DONE) begin
                cs_d.vec = cs_q.dflt;
            end else if (m_hit) begin
                cs_d.vec = tab_vec[m_idx];
            end else begin
                cs_d.vec  = cs_q.dflt;
                cs_d.miss = 1'b1;
            end
        end else if ((cs_q.st == ST_WAIT) && phy_ack) begin
            cs_d.st = ST_IDLE;
        end

        // Single pending slot: newest event wins, ranked tx > rts > done
        if (tx_req) begin
            cs_d.pend     = EV_TX;
            cs_d.pend_key = tx_dst;
        end else if (rts_seen) begin
            cs_d.pend     = EV_RTS;
            cs_d.pend_key = rts_src;
        end else if (xchg_done) begin
            cs_d.pend     = EV_DONE;
        end else if (serve) begin
            cs_d.pend     = EV_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q      <= '0;
            cs_q.st   <= ST_IDLE;
            cs_q.pend <= EV_NONE;
        end else begin
            cs_q <= cs_d;
        end
    end

    assign phy_valid = cs_q.wv;
    assign phy_vec   = cs_q.vec;
    assign lkp_miss  = cs_q.miss;

    // R8: the transfer pulse is one cycle wide
    assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        phy_valid |=> !phy_valid);

    // R8: no new transfer while the previous one is unacknowledged
    assert_wait_for_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((cs_q.st == ST_WAIT) && !phy_ack) |=> !phy_valid);

    // R11: the delivered vector only moves with a transfer pulse
    assert_vec_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !phy_valid |-> $stable(phy_vec));

    // R6: the miss flag only accompanies a transfer
    assert_miss_with_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_miss |-> phy_valid);

    // R5: an exchange-end event delivers the default vector and no miss
    assert_done_default_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (serve && (cs_q.pend == EV_DONE)) |=> (phy_vec == $past(cs_q.dflt)) && !lkp_miss);

    // R3, R4: a reported hit names a valid row holding the searched address
    assert_hit_consistent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (serve && m_hit) |-> tab_vld[m_idx] && (tab_mac[m_idx] == cs_q.pend_key));

endmodule

// File: tb/link_weight_ctrl_bench.sv
module link_weight_ctrl_bench;

    localparam int ENTRIES = 16;
    localparam int VW      = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 0, cfg_vld = 0, dflt_we = 0;
    logic [3:0]  cfg_idx = '0;
    logic [47:0] cfg_mac = '0, tx_dst = '0, rts_src = '0;
    logic [63:0] cfg_vec = '0, dflt_vec = '0;
    logic        tx_req = 0, rts_seen = 0, xchg_done = 0, phy_ack = 0;
    logic        phy_valid, lkp_miss;
    logic [63:0] phy_vec;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 0;

    always #2.5 clk = ~clk;

    link_weight_ctrl u_link_weight_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_vld(cfg_vld),
        .cfg_mac(cfg_mac), .cfg_vec(cfg_vec),
        .dflt_we(dflt_we), .dflt_vec(dflt_vec),
        .tx_req(tx_req), .tx_dst(tx_dst),
        .rts_seen(rts_seen), .rts_src(rts_src),
        .xchg_done(xchg_done),
        .phy_valid(phy_valid), .phy_ack(phy_ack),
        .phy_vec(phy_vec), .lkp_miss(lkp_miss)
    );

    // Closed-form station address per row
    function automatic logic [47:0] mac_of(input int i);
        return 48'h0A00_0000_0000 + 48'(i) * 48'h0001_0203_0405 + 48'h11;
    endfunction

    // Weight vector per row: antenna k I at [16k+7:16k], Q at [16k+15:16k+8] (R12)
    function automatic logic [63:0] vec_of(input int i, input int salt);
        logic [63:0] v;
        for (int k = 0; k < 4; k++) begin
            v[16*k +: 8]     = 8'(i * 16 + k * 2 + 1 + salt);
            v[16*k + 8 +: 8] = 8'(240 - i * 8 - k + salt * 3);
        end
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_row(input int i, input bit v, input logic [47:0] m, input logic [63:0] w);
        cfg_we = 1; cfg_idx = 4'(i); cfg_vld = v; cfg_mac = m; cfg_vec = w;
        @(negedge clk);
        cfg_we = 0;
    endtask

    // kind: 1 tx, 2 rts, 3 done
    task automatic fire(input int kind, input logic [47:0] key);
        tx_req = (kind == 1); rts_seen = (kind == 2); xchg_done = (kind == 3);
        tx_dst = key; rts_src = key;
        @(negedge clk);
        tx_req = 0; rts_seen = 0; xchg_done = 0;
    endtask

    // Called in cycle c+1; checks pulse in c+2, acks, checks drop and hold
    task automatic expect_xfer(input string req, input logic [63:0] ev, input bit em);
        chk(phy_valid == 1'b0, req, 64'(phy_valid), 64'd0);
        @(negedge clk);
        chk(phy_valid == 1'b1, req, 64'(phy_valid), 64'd1);
        chk(phy_vec == ev, req, phy_vec, ev);
        chk(lkp_miss == em, req, 64'(lkp_miss), 64'(em));
        phy_ack = 1;
        @(negedge clk);
        phy_ack = 0;
        chk(phy_valid == 1'b0 && phy_vec == ev, {req, " R8 R11 hold"}, phy_vec, ev);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [63:0] dv;
        logic [63:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset state
        chk(phy_valid == 0 && lkp_miss == 0, "R1 flags", {62'd0, phy_valid, lkp_miss}, 64'd0);
        chk(phy_vec == '0, "R1 vec", phy_vec, 64'd0);

        // R1 R5: default vector resets to zero
        fire(3, '0);
        expect_xfer("R5 reset default", 64'd0, 0);

        // R6: empty table misses
        fire(1, mac_of(3));
        expect_xfer("R6 empty table", 64'd0, 1);

        // R2 R5: program default and all rows
        dv = 64'h5A5A_A5A5_0F0F_F0F0;
        dflt_we = 1; dflt_vec = dv;
        @(negedge clk);
        dflt_we = 0;
        for (int i = 0; i < ENTRIES; i++) wr_row(i, 1, mac_of(i), vec_of(i, 0));

        // R2 R3 R4: sweep every row through transmit and RTS lookups
        for (int i = 0; i < ENTRIES; i++) begin
            fire(1, mac_of(i));
            expect_xfer($sformatf("R3 tx row %0d", i), vec_of(i, 0), 0);
            fire(2, mac_of(i));
            expect_xfer($sformatf("R4 rts row %0d", i), vec_of(i, 0), 0);
        end

        // R5: exchange end applies written default
        fire(3, mac_of(2));
        expect_xfer("R5 default", dv, 0);

        // R6: unknown address
        fire(2, 48'hFFFF_0000_1234);
        expect_xfer("R6 unknown", dv, 1);

        // R7: duplicate address, lower row wins
        wr_row(14, 1, mac_of(9), vec_of(14, 5));
        fire(1, mac_of(9));
        expect_xfer("R7 lowest row", vec_of(9, 0), 0);
        // R6: invalid row never matches; upper duplicate then serves
        wr_row(9, 0, mac_of(9), vec_of(9, 0));
        fire(1, mac_of(9));
        expect_xfer("R6 R7 invalid skipped", vec_of(14, 5), 0);
        wr_row(14, 0, mac_of(9), vec_of(14, 5));
        fire(2, mac_of(9));
        expect_xfer("R6 all invalid", dv, 1);

        // R11: writes do not disturb delivered vector
        fire(1, mac_of(2));
        expect_xfer("R11 before write", vec_of(2, 0), 0);
        held = phy_vec;
        wr_row(2, 1, mac_of(2), vec_of(2, 7));
        dflt_we = 1; dflt_vec = ~dv;
        @(negedge clk);
        dflt_we = 0;
        repeat (2) @(negedge clk);
        chk(phy_vec == held && phy_valid == 0, "R11 no change", phy_vec, held);
        fire(1, mac_of(2));
        expect_xfer("R11 R2 next lookup", vec_of(2, 7), 0);
        fire(3, '0);
        expect_xfer("R11 R5 new default", ~dv, 0);

        // R8 R9: events while waiting, newest kept
        fire(1, mac_of(4));
        chk(phy_valid == 0, "R9 pre", 64'(phy_valid), 64'd0);
        @(negedge clk);
        chk(phy_valid == 1 && phy_vec == vec_of(4, 0), "R9 first", phy_vec, vec_of(4, 0));
        fire(2, mac_of(5));
        fire(3, '0);
        fire(1, mac_of(6));
        repeat (3) begin
            chk(phy_valid == 0, "R8 no pulse before ack", 64'(phy_valid), 64'd0);
            @(negedge clk);
        end
        phy_ack = 1;
        @(negedge clk);
        phy_ack = 0;
        expect_xfer("R9 newest after ack", vec_of(6, 0), 0);
        chk(phy_valid == 0, "R9 slot empty", 64'(phy_valid), 64'd0);
        @(negedge clk);
        chk(phy_valid == 0, "R9 slot empty", 64'(phy_valid), 64'd0);

        // R10: simultaneous events
        tx_req = 1; rts_seen = 1; xchg_done = 1; tx_dst = mac_of(3); rts_src = mac_of(4);
        @(negedge clk);
        tx_req = 0; rts_seen = 0; xchg_done = 0;
        expect_xfer("R10 tx first", vec_of(3, 0), 0);
        rts_seen = 1; xchg_done = 1; rts_src = mac_of(4);
        @(negedge clk);
        rts_seen = 0; xchg_done = 0;
        expect_xfer("R10 rts over done", vec_of(4, 0), 0);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule